// File: doc/BRIEF.md
# Parallel Configuration Port Loader

This block feeds an 8-bit parallel configuration port on a programmable device. A host issues short commands that load a first and a last flash word address, load a byte count for bus transfers, and then start a transfer. The bytes come from one of two sources. The first is an external 16-bit flash that is reached through a shared flash controller, after an arbiter has granted ownership. The second is a first-word-fall-through FIFO that the host bus fills. The loader never parses the bitstream. Any command meant for the configured device travels inside the data.

Each byte is presented on the data lines with chip select and write asserted. One configuration clock pulse then marks it. When no byte is ready, the clock stays low, so the byte rate follows the source. A scrub command rereads the same flash range again and again. A programmable idle interval separates the passes, and the repetition continues until an abort arrives. Abort stops any activity at once.

Top module: `cfg_port_loader`

## Requirements
- R1: While reset is held and just after it is released, busy, fl_req, fl_rd, bf_rd, cp_csel, cp_write and cp_cclk are all low.
- R2: Opcode 3 (program from flash) reads every flash word from the start address (opcode 1) up to and including the stop address (opcode 2). Each 16-bit word goes out as two bytes, bits 15:8 first and bits 7:0 second.
- R3: cp_cclk rises only while cp_csel and cp_write are high, and it is high for exactly one cycle. cp_data holds the same value in the cycle before the rise and in the rise cycle. Stalls in the source add low clock cycles and produce no extra edge.
- R4: fl_rd is issued only while fl_req is high, fl_owner equals the block's owner ID (default 1) and fl_busy is low.
- R5: Opcode 5 (program from bus) sends exactly the byte count loaded by opcode 4, in FIFO order. It pops the FIFO only when the FIFO is not empty. A count of zero sends nothing, pops nothing and leaves the block idle.
- R6: Opcode 6 (scrub) runs the start-to-stop flash pass again and again. Between passes the block waits period+1 cycles, where period is the command argument. During the wait fl_req, cp_csel and cp_write are low and busy stays high.
- R7: Opcode 7 (abort), in any state, leaves busy, cp_csel, cp_write and fl_req low from the next cycle on. After it, no further byte is clocked out.
- R8: busy rises on the edge that accepts a program or scrub command. It stays high through the final clock-high cycle and is low in the cycle that follows.
- R9: While busy, every command except abort is ignored. This includes loads of start, stop and count, and new program commands.
- R10: A stop address below the start address makes a flash pass send the start word only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Opcode: 1 start, 2 stop, 3 program flash, 4 count, 5 program bus, 6 scrub, 7 abort |
| cmd_arg | input | AW | Address, count or scrub period |
| busy | output | 1 | Transfer or scrub in progress |
| fl_req | output | 1 | Flash ownership request to the arbiter |
| fl_owner | input | OWN_W | ID of the current flash owner |
| fl_rd | output | 1 | Flash read command, one cycle |
| fl_addr | output | AW | Flash word address |
| fl_busy | input | 1 | Flash controller busy |
| fl_dvalid | input | 1 | Flash read data valid, one cycle |
| fl_data | input | 16 | Flash read data |
| bf_empty | input | 1 | Bus FIFO empty |
| bf_data | input | 8 | Bus FIFO head byte |
| bf_rd | output | 1 | Bus FIFO pop |
| cp_data | output | 8 | Configuration port data |
| cp_write | output | 1 | Configuration port write strobe |
| cp_csel | output | 1 | Configuration port chip select |
| cp_cclk | output | 1 | Configuration clock |

## Verification
The bench varies flash latency from word to word and stalls the bus FIFO at irregular points. A loader that clocked on a fixed cadence would then emit stale or repeated bytes, and a loader that swapped the halves of a word would fail the byte-order comparison. Three bus cases matter: a FIFO holding more bytes than the count, a count of zero, and a stop address below the start. An off-by-one in the count or in the range test shows up as a missing or extra byte, or as a popped FIFO entry. Commands sent in mid-transfer must not move the range of the next pass. Aborts are issued both mid-stream and inside a scrub gap, and the scrub gap length is measured to catch a timer that is off by one or a request that stays held across the wait.

// File: rtl/cfg_port_loader.sv
module cfg_port_loader #(
  parameter int AW     = 20,
  parameter int CNT_W  = 16,
  parameter int PER_W  = 16,
  parameter int OWN_W  = 2,
  parameter int unsigned OWN_ID = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [AW-1:0]    cmd_arg,
  output logic             busy,
  output logic             fl_req,
  input  logic [OWN_W-1:0] fl_owner,
  output logic             fl_rd,
  output logic [AW-1:0]    fl_addr,
  input  logic             fl_busy,
  input  logic             fl_dvalid,
  input  logic [15:0]      fl_data,
  input  logic             bf_empty,
  input  logic [7:0]       bf_data,
  output logic             bf_rd,
  output logic [7:0]       cp_data,
  output logic             cp_write,
  output logic             cp_csel,
  output logic             cp_cclk
);

  localparam logic [2:0] OP_START = 3'd1;
  localparam logic [2:0] OP_STOP  = 3'd2;
  localparam logic [2:0] OP_PFL   = 3'd3;
  localparam logic [2:0] OP_CNT   = 3'd4;
  localparam logic [2:0] OP_PBUS  = 3'd5;
  localparam logic [2:0] OP_SCRUB = 3'd6;
  localparam logic [2:0] OP_ABORT = 3'd7;

  localparam logic [OWN_W-1:0] MY_ID   = OWN_ID[OWN_W-1:0];
  localparam logic [AW-1:0]    ADDR_1  = 1;
  localparam logic [CNT_W-1:0] CNT_1   = 1;
  localparam logic [CNT_W-1:0] CNT_0   = 0;
  localparam logic [PER_W-1:0] PER_1   = 1;
  localparam logic [PER_W-1:0] PER_0   = 0;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_FRD, S_FWAIT, S_BUS, S_EMIT, S_WAIT
  } st_t;

  st_t              st;
  logic             ph, lo_pend, from_bus, scrub_q;
  logic [7:0]       byte_q, lo_q;
  logic [AW-1:0]    addr_q, start_q, stop_q;
  logic [CNT_W-1:0] cnt_q, left_q;
  logic [PER_W-1:0] per_q, tmr_q;

  wire abort = cmd_valid && (cmd_op == OP_ABORT);

  assign busy     = (st != S_IDLE);
  assign fl_req   = (st == S_REQ) || (st == S_FRD) || (st == S_FWAIT) ||
                    ((st == S_EMIT) && !from_bus);
  assign fl_rd    = (st == S_FRD) && !fl_busy && !abort;
  assign fl_addr  = addr_q;
  assign bf_rd    = (st == S_BUS) && !bf_empty && !abort;
  assign cp_csel  = (st != S_IDLE) && (st != S_WAIT);
  assign cp_write = (st == S_EMIT);
  assign cp_cclk  = (st == S_EMIT) && ph;
  assign cp_data  = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      lo_pend  <= 1'b0;
      from_bus <= 1'b0;
      scrub_q  <= 1'b0;
      byte_q   <= '0;
      lo_q     <= '0;
      addr_q   <= '0;
      start_q  <= '0;
      stop_q   <= '0;
      cnt_q    <= '0;
      left_q   <= '0;
      per_q    <= '0;
      tmr_q    <= '0;
    end else if (abort) begin
      st      <= S_IDLE;
      ph      <= 1'b0;
      lo_pend <= 1'b0;
      scrub_q <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (cmd_valid) begin
          unique case (cmd_op)
            OP_START: start_q <= cmd_arg;
            OP_STOP:  stop_q  <= cmd_arg;
            OP_CNT:   cnt_q   <= cmd_arg[CNT_W-1:0];
            OP_PFL: begin
              addr_q   <= start_q;
              from_bus <= 1'b0;
              scrub_q  <= 1'b0;
              st       <= S_REQ;
            end
            OP_PBUS: begin
              from_bus <= 1'b1;
              left_q   <= cnt_q;
              st       <= (cnt_q == CNT_0) ? S_IDLE : S_BUS;
            end
            OP_SCRUB: begin
              addr_q   <= start_q;
              per_q    <= cmd_arg[PER_W-1:0];
              from_bus <= 1'b0;
              scrub_q  <= 1'b1;
              st       <= S_REQ;
            end
            default: ;
          endcase
        end
        S_REQ:   if (fl_owner == MY_ID) st <= S_FRD;
        S_FRD:   if (!fl_busy) st <= S_FWAIT;
        S_FWAIT: if (fl_dvalid) begin
          byte_q  <= fl_data[15:8];
          lo_q    <= fl_data[7:0];
          lo_pend <= 1'b1;
          ph      <= 1'b0;
          st      <= S_EMIT;
        end
        S_BUS: if (!bf_empty) begin
          byte_q <= bf_data;
          left_q <= left_q - CNT_1;
          ph     <= 1'b0;
          st     <= S_EMIT;
        end
        S_EMIT: begin
          if (!ph) begin
            ph <= 1'b1;
          end else begin
            ph <= 1'b0;
            if (from_bus) begin
              st <= (left_q == CNT_0) ? S_IDLE : S_BUS;
            end else if (lo_pend) begin
              byte_q  <= lo_q;
              lo_pend <= 1'b0;
            end else if (addr_q >= stop_q) begin
              if (scrub_q) begin
                addr_q <= start_q;
                tmr_q  <= per_q;
                st     <= S_WAIT;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              addr_q <= addr_q + ADDR_1;
              st     <= S_FRD;
            end
          end
        end
        S_WAIT: begin
          if (tmr_q == PER_0) st <= S_REQ;
          else tmr_q <= tmr_q - PER_1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_port_loader_chk.sv
module cfg_port_loader_chk #(
  parameter int OWN_W = 2,
  parameter int unsigned OWN_ID = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic             busy,
  input logic             fl_req,
  input logic [OWN_W-1:0] fl_owner,
  input logic             fl_rd,
  input logic             fl_busy,
  input logic             bf_empty,
  input logic             bf_rd,
  input logic [7:0]       cp_data,
  input logic             cp_write,
  input logic             cp_csel,
  input logic             cp_cclk
);
  localparam logic [OWN_W-1:0] MY_ID = OWN_ID[OWN_W-1:0];

  assert_clk_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_cclk |=> !cp_cclk);

  assert_clk_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_cclk) |-> (cp_csel && cp_write && $stable(cp_data)));

  assert_read_owned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |-> (fl_req && (fl_owner == MY_ID) && !fl_busy));

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bf_rd |-> !bf_empty);

  assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7) |=> (!busy && !cp_csel && !cp_write && !fl_req));

  assert_clk_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cp_cclk |-> busy);
endmodule

bind cfg_port_loader cfg_port_loader_chk #(.OWN_W(OWN_W), .OWN_ID(OWN_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .fl_req(fl_req), .fl_owner(fl_owner), .fl_rd(fl_rd),
  .fl_busy(fl_busy), .bf_empty(bf_empty), .bf_rd(bf_rd), .cp_data(cp_data),
  .cp_write(cp_write), .cp_csel(cp_csel), .cp_cclk(cp_cclk)
);

// File: tb/cfg_port_loader_tb.sv
module cfg_port_loader_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 20;
  localparam int WD    = 100000;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [AW-1:0] cmd_arg = '0;
  logic          busy, fl_req, fl_rd, bf_rd, cp_write, cp_csel, cp_cclk;
  logic [1:0]    fl_owner = '0;
  logic [AW-1:0] fl_addr;
  logic          fl_busy = 1'b0, fl_dvalid = 1'b0;
  logic [15:0]   fl_data = '0;
  logic          bf_empty = 1'b1;
  logic [7:0]    bf_data = '0, cp_data;

  always #(CLK_P/2) clk = ~clk;

  cfg_port_loader u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .busy(busy), .fl_req(fl_req), .fl_owner(fl_owner), .fl_rd(fl_rd), .fl_addr(fl_addr),
    .fl_busy(fl_busy), .fl_dvalid(fl_dvalid), .fl_data(fl_data), .bf_empty(bf_empty),
    .bf_data(bf_data), .bf_rd(bf_rd), .cp_data(cp_data), .cp_write(cp_write),
    .cp_csel(cp_csel), .cp_cclk(cp_cclk)
  );

  int checks = 0, errors = 0, cyc = 0;
  int rx_cnt = 0, last_rise = 0, run = 0, last_run = 0, own_viol = 0;
  bit mon_chk = 1'b1, stall_en = 1'b0, prev_cclk = 1'b0;
  string mon_tag = "R2";
  logic [7:0] expq[$];
  logic [7:0] fifo[$];

  function automatic logic [15:0] fw(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic send_cmd(input logic [2:0] op, input logic [AW-1:0] arg);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic exp_flash(input logic [AW-1:0] s, input logic [AW-1:0] e);
    logic [AW-1:0] a = s;
    forever begin
      expq.push_back(fw(a)[15:8]);
      expq.push_back(fw(a)[7:0]);
      if (a >= e) break;
      a = a + 1;
    end
  endtask

  task automatic wait_idle(input string tag, output int idle_at);
    int n = 0;
    idle_at = 0;
    forever begin
      @(negedge clk);
      if (!busy) begin idle_at = cyc; break; end
      n++;
      if (n > 5000) begin chk(1'b0, tag, 32'd1, 32'd0); break; end
    end
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (expq.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // flash, arbiter and bus FIFO models, updated just after each edge
  initial begin
    bit s_rd, s_req, s_bfrd;
    logic [AW-1:0] s_addr, paddr;
    int lat, gcnt;
    lat = 0; gcnt = 0; paddr = '0;
    forever begin
      @(negedge clk);
      s_rd = fl_rd; s_addr = fl_addr; s_req = fl_req; s_bfrd = bf_rd;
      @(posedge clk); #1;
      if (s_bfrd && fifo.size() > 0) void'(fifo.pop_front());
      fl_dvalid = 1'b0;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin fl_dvalid = 1'b1; fl_data = fw(paddr); fl_busy = 1'b0; end
      end
      if (s_rd) begin paddr = s_addr; lat = 1 + int'(s_addr % 3); fl_busy = 1'b1; end
      if (s_req) begin if (gcnt < 2) gcnt++; end else gcnt = 0;
      fl_owner = (gcnt >= 2) ? 2'd1 : 2'd0;
      bf_empty = (fifo.size() == 0) || (stall_en && (cyc % 3 == 0));
      bf_data  = (fifo.size() > 0) ? fifo[0] : 8'h00;
    end
  end

  // monitor: pops the scoreboard on every configuration clock rise
  always @(negedge clk) begin
    if (rst_n) begin
      if (cp_cclk && !prev_cclk) begin
        rx_cnt++;
        last_rise = cyc;
        if (mon_chk) begin
          if (expq.size() == 0) chk(1'b0, "R3 unexpected byte", cp_data, 0);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            chk(cp_data == e && cp_csel && cp_write, mon_tag, {cp_csel, cp_write, cp_data}, {2'b11, e});
          end
        end
      end
      if (fl_rd && fl_owner != 2'd1) own_viol++;
      if (busy && !fl_req && !cp_csel) run++;
      else begin if (run > 0) last_run = run; run = 0; end
    end
    prev_cclk = cp_cclk;
  end

  initial begin
    repeat (WD) @(posedge clk);
    chk(1'b0, "watchdog", cyc, WD);
    summary();
  end

  initial begin
    int t, base;
    repeat (3) @(negedge clk);
    chk({busy, fl_req, fl_rd, bf_rd, cp_csel, cp_write, cp_cclk} == 7'd0, "R1 in reset",
        {busy, fl_req, fl_rd, bf_rd, cp_csel, cp_write, cp_cclk}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, fl_req, fl_rd, bf_rd, cp_csel, cp_write, cp_cclk} == 7'd0, "R1 after reset",
        {busy, fl_req, fl_rd, bf_rd, cp_csel, cp_write, cp_cclk}, 0);

    // R2 and R8: four-word flash pass
    mon_tag = "R2 flash byte";
    send_cmd(3'd1, 20'h00010);
    send_cmd(3'd2, 20'h00013);
    exp_flash(20'h00010, 20'h00013);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd3; cmd_arg = '0;
    @(negedge clk); cmd_valid = 1'b0;
    chk(busy, "R8 busy after start", busy, 1);
    wait_idle("R2 idle", t);
    chk(expq.size() == 0, "R2 all bytes", expq.size(), 0);
    chk(t - last_rise == 1, "R8 busy drop", t - last_rise, 1);

    // R10: stop below start
    mon_tag = "R10 byte";
    send_cmd(3'd1, 20'h00020);
    send_cmd(3'd2, 20'h0001F);
    base = rx_cnt;
    exp_flash(20'h00020, 20'h00020);
    send_cmd(3'd3, '0);
    wait_idle("R10 idle", t);
    chk(rx_cnt - base == 2, "R10 byte count", rx_cnt - base, 2);

    // R5 and R3: bus transfer with stalls, FIFO deeper than count
    mon_tag = "R5 bus byte";
    stall_en = 1'b1;
    foreach (fifo[i]) ;
    for (int i = 1; i <= 7; i++) fifo.push_back(8'(i * 17));
    for (int i = 1; i <= 5; i++) expq.push_back(8'(i * 17));
    send_cmd(3'd4, 20'd5);
    base = rx_cnt;
    send_cmd(3'd5, '0);
    wait_idle("R5 idle", t);
    chk(rx_cnt - base == 5, "R5 byte count", rx_cnt - base, 5);
    chk(fifo.size() == 2, "R5 fifo left", fifo.size(), 2);
    stall_en = 1'b0;

    // R5: zero count
    send_cmd(3'd4, 20'd0);
    base = rx_cnt;
    send_cmd(3'd5, '0);
    repeat (10) @(negedge clk);
    chk(rx_cnt == base && fifo.size() == 2 && !busy, "R5 zero count",
        {rx_cnt - base, fifo.size()}, 2);
    fifo.delete();

    // R9: commands during a transfer are ignored
    mon_tag = "R9 byte";
    send_cmd(3'd1, 20'h00030);
    send_cmd(3'd2, 20'h00031);
    exp_flash(20'h00030, 20'h00031);
    base = rx_cnt;
    send_cmd(3'd3, '0);
    send_cmd(3'd2, 20'h00040);
    send_cmd(3'd1, 20'h00090);
    send_cmd(3'd5, '0);
    wait_idle("R9 idle", t);
    chk(rx_cnt - base == 4, "R9 first pass", rx_cnt - base, 4);
    exp_flash(20'h00030, 20'h00031);
    base = rx_cnt;
    send_cmd(3'd3, '0);
    wait_idle("R9 idle 2", t);
    chk(rx_cnt - base == 4 && expq.size() == 0, "R9 range kept", rx_cnt - base, 4);

    // R6: scrub, three passes, then abort inside the gap
    mon_tag = "R6 scrub byte";
    send_cmd(3'd1, 20'h00050);
    send_cmd(3'd2, 20'h00051);
    for (int p = 0; p < 3; p++) exp_flash(20'h00050, 20'h00051);
    last_run = 0;
    send_cmd(3'd6, 20'd6);
    wait_drain("R6 three passes");
    chk(last_run == 7, "R6 gap length", last_run, 7);
    repeat (2) @(negedge clk);
    chk(busy && !fl_req && !cp_csel, "R6 wait state", {busy, fl_req, cp_csel}, 3'b100);
    base = rx_cnt;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd7;
    @(negedge clk); cmd_valid = 1'b0;
    chk(!busy && !fl_req && !cp_csel, "R7 abort in gap", {busy, fl_req, cp_csel}, 0);
    repeat (60) @(negedge clk);
    chk(rx_cnt == base, "R6 scrub stopped", rx_cnt - base, 0);

    // R7: abort mid-stream
    mon_chk = 1'b0;
    send_cmd(3'd1, 20'h00060);
    send_cmd(3'd2, 20'h0006F);
    base = rx_cnt;
    send_cmd(3'd3, '0);
    while (rx_cnt - base < 5) @(negedge clk);
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd7;
    @(negedge clk); cmd_valid = 1'b0;
    chk({busy, cp_csel, cp_write, fl_req} == 4'd0, "R7 abort outputs",
        {busy, cp_csel, cp_write, fl_req}, 0);
    base = rx_cnt;
    repeat (60) @(negedge clk);
    chk(rx_cnt == base, "R7 no bytes after abort", rx_cnt - base, 0);

    chk(own_viol == 0, "R4 read without ownership", own_viol, 0);
    summary();
  end
endmodule